// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Responder

This block is the requesting side of a seven-level prioritized interrupt bus. Local logic pulses a request strobe together with a priority level (1 to 7) and an 8-bit identifier. The block then pulls down the one active-low request line that belongs to that level and keeps it low until a handler collects the identifier.

The handler collects it through an acknowledge that is passed along a chain of boards. When the incoming acknowledge is low and the address strobe is asserted, the block compares the level carried on address bits A3..A1 with its own pending level. If they match, it consumes the acknowledge: it drives its identifier on the low data byte, asserts a data-acknowledge and releases its request line. If they do not match, or nothing is pending, it passes the acknowledge to the next board. Exactly one board answers each acknowledge. All bus inputs are sampled on the rising clock edge, and every output is a decode of registered state.

Top module: `irq_chain_responder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, all seven request lines are high, `iack_out_n` and `dtack_n` are high, `data_oe` is low and `data_o` is zero.
- R2: A strobe with a level L from 1 to 7 accepted at an edge drives `irq_n[L-1]` low from that edge on, and no other request line changes.
- R3: A strobe is ignored when its level is 0, when a request is already pending, or while the block is answering. The pending level and identifier are left unchanged.
- R4: With `iack_in_n` and `as_n` low and no match, `iack_out_n` goes low one cycle later. It stays low while `iack_in_n` stays low and returns high one cycle after `iack_in_n` rises.
- R5: With `iack_in_n`, `as_n` and `ds_n` low, a request pending and A3..A1 equal to its level, the next cycle shows `data_oe` high, the identifier on `data_o`, `dtack_n` low and every request line high. A match seen while `ds_n` is high waits and neither answers nor passes.
- R6: The answer is held while `ds_n` stays low. One cycle after `ds_n` rises, `data_oe` is low, `data_o` is zero and `dtack_n` is high.
- R7: After an answer, no new decision is taken until `iack_in_n` has been seen high, so `iack_out_n` stays high for the rest of that acknowledge.
- R8: `iack_out_n` is never low while `data_oe` is high.
- R9: No decision is taken while `as_n` is high, even if `iack_in_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_stb | input | 1 | One-cycle request strobe from local logic |
| req_lvl | input | 3 | Requested priority level, 1 to 7 |
| req_id | input | 8 | Identifier returned when the request is acknowledged |
| irq_n | output | 7 | Request lines, bit k is level k+1, active low |
| iack_in_n | input | 1 | Acknowledge from the upstream board, active low |
| iack_out_n | output | 1 | Acknowledge to the downstream board, active low |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| ack_lvl | input | 3 | Acknowledged level from address bits A3..A1 |
| data_o | output | 8 | Identifier byte, zero when not driven |
| data_oe | output | 1 | Data bus drive enable, high only while answering |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
Every result is due exactly one rising edge after the inputs that cause it: the request lines after the strobe, the forwarded acknowledge and the answer after the sampled chain inputs, and the release after `ds_n` or `iack_in_n` rises. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each vector checks the state that a single clock edge produced. Reset is checked while asynchronous, both during a pending request and in the middle of an answer.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_PASS   = 2'd1,
    CH_ANSWER = 2'd2,
    CH_DRAIN  = 2'd3
  } chain_st_e;
endpackage

// File: rtl/irqc_request.sv
module irqc_request #(
  parameter int LVL_W   = 3,
  parameter int ID_W    = 8,
  parameter int NUM_LVL = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_stb,
  input  logic [LVL_W-1:0]   req_lvl,
  input  logic [ID_W-1:0]    req_id,
  input  logic               busy,
  input  logic               take,
  output logic               pend_o,
  output logic [LVL_W-1:0]   lvl_o,
  output logic [ID_W-1:0]    id_o,
  output logic [NUM_LVL-1:0] irq_n_o
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVL);

  logic             pend_q, pend_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic             accept;
  logic             ce;

  always_comb begin
    accept = req_stb && !pend_q && !busy &&
             (req_lvl != '0) && (req_lvl <= TOP_LVL);
    ce     = accept || take;
    pend_d = pend_q;
    lvl_d  = lvl_q;
    id_d   = id_q;
    if (take) begin
      pend_d = 1'b0;
    end else if (accept) begin
      pend_d = 1'b1;
      lvl_d  = req_lvl;
      id_d   = req_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lvl_q  <= '0;
      id_q   <= '0;
    end else if (ce) begin
      pend_q <= pend_d;
      lvl_q  <= lvl_d;
      id_q   <= id_d;
    end
  end

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_line
    assign irq_n_o[g] = !(pend_q && (lvl_q == LVL_W'(g + 1)));
  end

  assign pend_o = pend_q;
  assign lvl_o  = lvl_q;
  assign id_o   = id_q;

  // R2: at most one request line low
  a_r2_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n_o));
  // R2: accepted level shows on its own line
  a_r2_level_line: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !irq_n_o[lvl_q - LVL_W'(1)]);
  // R3: pending contents are frozen
  a_r3_hold_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take) |=> ($stable(lvl_q) && $stable(id_q)));
  // R5: taking the request releases every line
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (&irq_n_o));
endmodule

// File: rtl/irqc_chain.sv
module irqc_chain
  import irqc_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack_in_n,
  input  logic             as_n,
  input  logic             ds_n,
  input  logic [LVL_W-1:0] ack_lvl,
  input  logic             pend,
  input  logic [LVL_W-1:0] own_lvl,
  output logic             take,
  output logic             pass_o,
  output logic             answer_o
);
  chain_st_e st_q, st_d;
  logic      sel;
  logic      hit;

  always_comb begin
    sel  = !iack_in_n && !as_n;
    hit  = pend && (ack_lvl == own_lvl);
    st_d = st_q;
    take = 1'b0;
    unique case (st_q)
      CH_IDLE: begin
        if (sel) begin
          if (!hit) begin
            st_d = CH_PASS;
          end else if (!ds_n) begin
            st_d = CH_ANSWER;
            take = 1'b1;
          end
        end
      end
      CH_PASS:   if (iack_in_n) st_d = CH_IDLE;
      CH_ANSWER: if (ds_n)      st_d = CH_DRAIN;
      CH_DRAIN:  if (iack_in_n) st_d = CH_IDLE;
      default:   st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CH_IDLE;
    else        st_q <= st_d;
  end

  assign pass_o   = (st_q == CH_PASS);
  assign answer_o = (st_q == CH_ANSWER);

  // R4: forwarding only follows a low upstream acknowledge
  a_r4_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> $past(!iack_in_n));
  // R6: answer held while data strobe low
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (answer_o && !ds_n) |=> answer_o);
  // R7: no forwarding after answering in the same acknowledge
  a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == CH_DRAIN) && !iack_in_n) |=> !pass_o);
  // R9: no decision without address strobe
  a_r9_no_as: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == CH_IDLE) && as_n) |=> (st_q == CH_IDLE));
endmodule

// File: rtl/irq_chain_responder.sv
module irq_chain_responder #(
  parameter int LVL_W   = 3,
  parameter int ID_W    = 8,
  parameter int NUM_LVL = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_stb,
  input  logic [LVL_W-1:0]   req_lvl,
  input  logic [ID_W-1:0]    req_id,
  output logic [NUM_LVL-1:0] irq_n,
  input  logic               iack_in_n,
  output logic               iack_out_n,
  input  logic               as_n,
  input  logic               ds_n,
  input  logic [LVL_W-1:0]   ack_lvl,
  output logic [ID_W-1:0]    data_o,
  output logic               data_oe,
  output logic               dtack_n
);
  logic             pend;
  logic [LVL_W-1:0] own_lvl;
  logic [ID_W-1:0]  own_id;
  logic             take;
  logic             pass;
  logic             answer;

  irqc_request #(
    .LVL_W(LVL_W), .ID_W(ID_W), .NUM_LVL(NUM_LVL)
  ) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_stb (req_stb),
    .req_lvl (req_lvl),
    .req_id  (req_id),
    .busy    (answer),
    .take    (take),
    .pend_o  (pend),
    .lvl_o   (own_lvl),
    .id_o    (own_id),
    .irq_n_o (irq_n)
  );

  irqc_chain #(
    .LVL_W(LVL_W)
  ) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .iack_in_n (iack_in_n),
    .as_n      (as_n),
    .ds_n      (ds_n),
    .ack_lvl   (ack_lvl),
    .pend      (pend),
    .own_lvl   (own_lvl),
    .take      (take),
    .pass_o    (pass),
    .answer_o  (answer)
  );

  assign iack_out_n = !pass;
  assign dtack_n    = !answer;
  assign data_oe    = answer;
  assign data_o     = answer ? own_id : '0;

  // R8: never answer and forward together
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_oe && !iack_out_n));
  // R5: driving the bus starts with the request line released
  a_r5_drive_released: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> (&irq_n));
  // R5: data acknowledge only comes with a driven bus
  a_r5_dtack_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> data_oe);
endmodule

// File: tb/tb_irq_chain_responder.sv
`timescale 1ns/1ps
module tb_irq_chain_responder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_stb;
  logic [2:0] req_lvl;
  logic [7:0] req_id;
  logic [6:0] irq_n;
  logic       iack_in_n;
  logic       iack_out_n;
  logic       as_n;
  logic       ds_n;
  logic [2:0] ack_lvl;
  logic [7:0] data_o;
  logic       data_oe;
  logic       dtack_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_chain_responder dut (
    .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_lvl(req_lvl),
    .req_id(req_id), .irq_n(irq_n), .iack_in_n(iack_in_n),
    .iack_out_n(iack_out_n), .as_n(as_n), .ds_n(ds_n), .ack_lvl(ack_lvl),
    .data_o(data_o), .data_oe(data_oe), .dtack_n(dtack_n)
  );

  // {tag, req, lvl, id, iack_in_n, as_n, ds_n, ack_lvl,
  //  exp irq_n, exp iack_out_n, exp dtack_n, exp data_oe, exp data_o}
  localparam int NV = 22;
  localparam logic [39:0] VEC [0:NV-1] = '{
    {4'd2, 1'b1,3'd3,8'hA5, 1'b1,1'b1,1'b1,3'd0, 7'h7B,1'b1,1'b1,1'b0,8'h00},
    {4'd2, 1'b0,3'd0,8'h00, 1'b1,1'b1,1'b1,3'd0, 7'h7B,1'b1,1'b1,1'b0,8'h00},
    {4'd3, 1'b1,3'd5,8'h3C, 1'b1,1'b1,1'b1,3'd0, 7'h7B,1'b1,1'b1,1'b0,8'h00},
    {4'd4, 1'b0,3'd0,8'h00, 1'b0,1'b0,1'b0,3'd2, 7'h7B,1'b0,1'b1,1'b0,8'h00},
    {4'd4, 1'b0,3'd0,8'h00, 1'b0,1'b0,1'b0,3'd3, 7'h7B,1'b0,1'b1,1'b0,8'h00},
    {4'd4, 1'b0,3'd0,8'h00, 1'b1,1'b1,1'b1,3'd0, 7'h7B,1'b1,1'b1,1'b0,8'h00},
    {4'd5, 1'b0,3'd0,8'h00, 1'b0,1'b0,1'b0,3'd3, 7'h7F,1'b1,1'b0,1'b1,8'hA5},
    {4'd8, 1'b0,3'd0,8'h00, 1'b0,1'b0,1'b0,3'd3, 7'h7F,1'b1,1'b0,1'b1,8'hA5},
    {4'd6, 1'b0,3'd0,8'h00, 1'b0,1'b0,1'b1,3'd3, 7'h7F,1'b1,1'b1,1'b0,8'h00},
    {4'd7, 1'b0,3'd0,8'h00, 1'b0,1'b0,1'b1,3'd3, 7'h7F,1'b1,1'b1,1'b0,8'h00},
    {4'd7, 1'b0,3'd0,8'h00, 1'b1,1'b1,1'b1,3'd0, 7'h7F,1'b1,1'b1,1'b0,8'h00},
    {4'd4, 1'b0,3'd0,8'h00, 1'b0,1'b0,1'b0,3'd3, 7'h7F,1'b0,1'b1,1'b0,8'h00},
    {4'd4, 1'b0,3'd0,8'h00, 1'b1,1'b1,1'b1,3'd0, 7'h7F,1'b1,1'b1,1'b0,8'h00},
    {4'd3, 1'b1,3'd0,8'h11, 1'b1,1'b1,1'b1,3'd0, 7'h7F,1'b1,1'b1,1'b0,8'h00},
    {4'd2, 1'b1,3'd7,8'h5A, 1'b1,1'b1,1'b1,3'd0, 7'h3F,1'b1,1'b1,1'b0,8'h00},
    {4'd5, 1'b0,3'd0,8'h00, 1'b0,1'b0,1'b1,3'd7, 7'h3F,1'b1,1'b1,1'b0,8'h00},
    {4'd5, 1'b0,3'd0,8'h00, 1'b0,1'b0,1'b0,3'd7, 7'h7F,1'b1,1'b0,1'b1,8'h5A},
    {4'd3, 1'b1,3'd1,8'h99, 1'b0,1'b0,1'b0,3'd7, 7'h7F,1'b1,1'b0,1'b1,8'h5A},
    {4'd6, 1'b0,3'd0,8'h00, 1'b1,1'b1,1'b1,3'd0, 7'h7F,1'b1,1'b1,1'b0,8'h00},
    {4'd3, 1'b0,3'd0,8'h00, 1'b1,1'b1,1'b1,3'd0, 7'h7F,1'b1,1'b1,1'b0,8'h00},
    {4'd9, 1'b0,3'd0,8'h00, 1'b0,1'b1,1'b0,3'd0, 7'h7F,1'b1,1'b1,1'b0,8'h00},
    {4'd9, 1'b0,3'd0,8'h00, 1'b1,1'b1,1'b1,3'd0, 7'h7F,1'b1,1'b1,1'b0,8'h00}
  };

  localparam logic [17:0] IDLE_OUT = {7'h7F, 1'b1, 1'b1, 1'b0, 8'h00};

  function automatic logic [17:0] outs();
    return {irq_n, iack_out_n, dtack_n, data_oe, data_o};
  endfunction

  task automatic check(input int tag, input logic [17:0] exp, input string what);
    logic [17:0] act;
    act = outs();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic rq, input logic [2:0] lv, input logic [7:0] id,
                       input logic ia, input logic as, input logic ds,
                       input logic [2:0] al);
    req_stb = rq; req_lvl = lv; req_id = id;
    iack_in_n = ia; as_n = as; ds_n = ds; ack_lvl = al;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 3'd0);
    repeat (3) @(negedge clk);
    check(1, IDLE_OUT, "outputs in reset");          // R1
    rst_n = 1'b1;
    @(negedge clk);
    check(1, IDLE_OUT, "outputs after release");     // R1

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][35], VEC[i][34:32], VEC[i][31:24], VEC[i][23],
            VEC[i][22], VEC[i][21], VEC[i][20:18]);
      @(negedge clk);
      check(int'(VEC[i][39:36]), VEC[i][17:0], $sformatf("vector %0d", i));
    end

    // R2: lowest level uses bit 0
    drive(1'b1, 3'd1, 8'hC3, 1'b1, 1'b1, 1'b1, 3'd0);
    @(negedge clk);
    drive(1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 3'd0);
    check(2, {7'h7E, 1'b1, 1'b1, 1'b0, 8'h00}, "level 1 line");

    // R1: asynchronous reset clears a pending request
    #1 rst_n = 1'b0;
    #1 check(1, IDLE_OUT, "reset drops pending request");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, IDLE_OUT, "no request after reset");

    // R1: reset in the middle of an answer
    drive(1'b1, 3'd4, 8'hE7, 1'b1, 1'b1, 1'b1, 3'd0);
    @(negedge clk);
    drive(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd4);
    @(negedge clk);
    check(5, {7'h7F, 1'b1, 1'b0, 1'b1, 8'hE7}, "answer level 4");
    #1 rst_n = 1'b0;
    #1 check(1, IDLE_OUT, "reset during answer");
    drive(1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, IDLE_OUT, "idle after answer reset");

    finish_run();
  end
endmodule